// File: doc/BRIEF.md
# Multiphase Interleaved PWM Generator

This block drives up to four interleaved buck-converter channels from one shared period counter. After reset it reads back which of its upper channel pads are strapped high, takes the number of active phases from that, and spaces the active channels evenly around the switching period. Each channel output is driven high or low, or is left floating (high impedance). A floating output tells the external gate driver to turn off both switches.

A sequencer supplies a common duty command, a signed current-balance correction for each channel, a run request, a float request and an active-low disable. The correction is subtracted from the duty command, so a channel that carries more than its share of current gets a narrower pulse. A pulse output marks every channel period start, so it runs at the combined ripple rate. The period count and the phase count are captured once, in the first clock after reset is released. All timing is counted in ticks of that clock.

Top module: `mphase_pwm_gen`

## Requirements
- R1: The phase count N is the channel total minus the number of consecutive high bits of `strap_i`, counted down from the top bit, with a floor of 2. With 4 channels, strap 4'b0000 gives N=4, 4'b1000 gives N=3, and 4'b1100 or 4'b1110 gives N=2. A channel with index N or higher keeps `pwm_oe_o` low at all times.
- R2: The shared counter runs 0..P-1, where P is the captured period. Active channel k starts its period when the counter equals floor(k*P/N).
- R3: `ripple_o` pulses for one cycle at every start of an active channel, which gives N pulses per period.
- R4: At its period start a channel goes high if its effective duty D is above 0. It then stays high for exactly D cycles of each P-cycle period. A larger duty gives a longer high time.
- R5: D = duty_i - corr_k, where corr_k is the signed two's-complement field `corr_i[k*COR_W +: COR_W]`. D is clamped to the range 0..P-1.
- R6: A channel samples duty_i and its correction only in the cycle of its own period start. Changes at any other time do not affect the pulse in progress.
- R7: When `dis_n_i` is low, every `pwm_oe_o` bit is low one clock later.
- R8: When `hiz_i` is high, every output floats one clock later. When the output is driven but `run_i` is low, the active outputs are driven low (`pwm_oe_o`=1, `pwm_o`=0).
- R9: During reset and until the capture cycle, all outputs float with `pwm_o` and `ripple_o` low. `strap_i` and `period_i` are sampled only once, in the first clock after reset is released. Later changes to them have no effect.
- R10: Every output is registered: a change of an input takes effect at the first clock edge after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| strap_i | input | MAX_PH | Read-back of the channel pads; a high bit means that pad is strapped high |
| period_i | input | CNT_W | Period length P in clock ticks (P >= 4) |
| duty_i | input | CNT_W | Common duty command in ticks |
| corr_i | input | MAX_PH*COR_W | Signed per-channel duty corrections |
| run_i | input | 1 | Switching enable; when low, driven outputs are held low |
| hiz_i | input | 1 | Float request from the sequencer |
| dis_n_i | input | 1 | Active-low disable; when low, all outputs float |
| pwm_o | output | MAX_PH | Channel PWM level (0 whenever not driven) |
| pwm_oe_o | output | MAX_PH | Channel drive enable; 0 means high impedance |
| ripple_o | output | 1 | One-cycle pulse at each active channel period start |

## Verification
The hardest case to reach is a duty or correction change that lands partway through one channel's period while another channel is just starting. The pulse in progress must keep its old width while the starting channel picks up the new one. The bench gets there by changing the duty every few cycles at spacings that do not divide the period, while a reference model tracks each channel's load instant. The phase-count decode and the offset rounding can only be reached through reset, so the bench resets the block several times with different strap patterns and with an odd period.

// File: rtl/mpwm_pkg.sv
package mpwm_pkg;

  // Three-way drive of a channel pad
  typedef enum logic [1:0] {
    DRV_OFF = 2'd0,
    DRV_LO  = 2'd1,
    DRV_HI  = 2'd2
  } drive_e;

endpackage

// File: rtl/mpwm_rst_sync.sv
module mpwm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync_o
);

  logic stg1_q, stg2_q;
  logic stg1_d, stg2_d;

  always_comb begin
    stg1_d = 1'b1;
    stg2_d = stg1_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg1_q <= 1'b0;
      stg2_q <= 1'b0;
    end else begin
      stg1_q <= stg1_d;
      stg2_q <= stg2_d;
    end
  end

  assign rst_n_sync_o = stg2_q;

endmodule

// File: rtl/mpwm_phase_plan.sv
// Decodes the strap read-back into a phase count and works out the
// start offset of every channel within the shared period.
module mpwm_phase_plan #(
  parameter int MAX_PH = 4,
  parameter int CNT_W  = 10,
  parameter int IDX_W  = $clog2(MAX_PH + 1)
) (
  input  logic [MAX_PH-1:0] strap_i,
  input  logic [CNT_W-1:0]  period_i,
  output logic [IDX_W-1:0]  nph_o,
  output logic [MAX_PH-1:0] act_o,
  output logic [CNT_W-1:0]  off_o [MAX_PH]
);

  localparam int PW = CNT_W + IDX_W;

  logic [IDX_W-1:0] strip;
  logic [IDX_W-1:0] nph;
  logic             in_run;

  // count consecutive high straps from the top channel downward
  always_comb begin
    strip  = '0;
    in_run = 1'b1;
    for (int i = MAX_PH - 1; i >= 0; i--) begin
      if (in_run && strap_i[i]) begin
        strip = strip + IDX_W'(1);
      end else begin
        in_run = 1'b0;
      end
    end
    nph = IDX_W'(MAX_PH) - strip;
    if (nph < IDX_W'(2)) begin
      nph = IDX_W'(2);
    end
  end

  assign nph_o = nph;

  genvar k;
  generate
    for (k = 0; k < MAX_PH; k++) begin : g_off
      logic [PW-1:0] prod;
      assign act_o[k] = (IDX_W'(k) < nph);
      assign prod     = PW'(k) * PW'(period_i);
      assign off_o[k] = act_o[k] ? CNT_W'(prod / PW'(nph)) : '0;
    end
  endgenerate

endmodule

// File: rtl/mpwm_chan.sv
// One PWM channel: local phase position, corrected and clamped duty,
// load at the channel period start, registered three-way drive.
module mpwm_chan
  import mpwm_pkg::*;
#(
  parameter int CNT_W = 10,
  parameter int COR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             act_i,
  input  logic             drive_ok_i,
  input  logic             run_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] per_i,
  input  logic [CNT_W-1:0] off_i,
  input  logic [CNT_W-1:0] duty_i,
  input  logic [COR_W-1:0] corr_i,
  output drive_e           drv_o,
  output logic             start_o
);

  localparam int EW = CNT_W + 2;

  logic [CNT_W:0]   pos;
  logic             at_start;
  logic [EW-1:0]    diff;
  logic [EW-1:0]    pm1;
  logic [CNT_W-1:0] eff;
  logic             hi_next;
  logic [CNT_W-1:0] dcur_q, dcur_d;
  logic             dcur_ld;
  drive_e           drv_q, drv_d;

  // position inside this channel's own period
  always_comb begin
    if (cnt_i >= off_i) begin
      pos = {1'b0, cnt_i} - {1'b0, off_i};
    end else begin
      pos = {1'b0, cnt_i} + {1'b0, per_i} - {1'b0, off_i};
    end
  end

  assign at_start = (pos == '0);

  // corrected duty, clamped to 0..P-1
  always_comb begin
    diff = {2'b00, duty_i} - {{(EW-COR_W){corr_i[COR_W-1]}}, corr_i};
    pm1  = {2'b00, per_i} - EW'(1);
    if (diff[EW-1]) begin
      eff = '0;
    end else if (diff > pm1) begin
      eff = pm1[CNT_W-1:0];
    end else begin
      eff = diff[CNT_W-1:0];
    end
  end

  // duty register loads only at the period start (no runt pulses)
  assign dcur_ld = en_i && at_start;

  always_comb begin
    dcur_d = dcur_q;
    if (dcur_ld) begin
      dcur_d = eff;
    end
  end

  always_comb begin
    if (at_start) begin
      hi_next = (eff != '0);
    end else begin
      hi_next = (pos < {1'b0, dcur_q});
    end
  end

  always_comb begin
    if (!en_i || !act_i || !drive_ok_i) begin
      drv_d = DRV_OFF;
    end else if (!run_i) begin
      drv_d = DRV_LO;
    end else if (hi_next) begin
      drv_d = DRV_HI;
    end else begin
      drv_d = DRV_LO;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dcur_q <= '0;
      drv_q  <= DRV_OFF;
    end else begin
      dcur_q <= dcur_d;
      drv_q  <= drv_d;
    end
  end

  assign drv_o   = drv_q;
  assign start_o = en_i && act_i && at_start;

endmodule

// File: rtl/mphase_pwm_gen.sv
module mphase_pwm_gen
  import mpwm_pkg::*;
#(
  parameter int MAX_PH = 4,
  parameter int CNT_W  = 10,
  parameter int COR_W  = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [MAX_PH-1:0]       strap_i,
  input  logic [CNT_W-1:0]        period_i,
  input  logic [CNT_W-1:0]        duty_i,
  input  logic [MAX_PH*COR_W-1:0] corr_i,
  input  logic                    run_i,
  input  logic                    hiz_i,
  input  logic                    dis_n_i,
  output logic [MAX_PH-1:0]       pwm_o,
  output logic [MAX_PH-1:0]       pwm_oe_o,
  output logic                    ripple_o
);

  localparam int IDX_W = $clog2(MAX_PH + 1);

  logic rst_int_n;

  // captured configuration
  logic                det_q, det_d;
  logic [MAX_PH-1:0]   act_q, act_d;
  logic [CNT_W-1:0]    per_q, per_d;
  logic [CNT_W-1:0]    off_q [MAX_PH];
  logic [CNT_W-1:0]    off_d [MAX_PH];
  logic [CNT_W-1:0]    cnt_q, cnt_d;
  logic                rip_q, rip_d;

  logic [IDX_W-1:0]    plan_nph;
  logic [MAX_PH-1:0]   plan_act;
  logic [CNT_W-1:0]    plan_off [MAX_PH];

  logic [MAX_PH-1:0]   start;
  drive_e              drv [MAX_PH];
  logic                drive_ok;

  mpwm_rst_sync u_rst (
    .clk          (clk),
    .rst_n        (rst_n),
    .rst_n_sync_o (rst_int_n)
  );

  mpwm_phase_plan #(
    .MAX_PH (MAX_PH),
    .CNT_W  (CNT_W),
    .IDX_W  (IDX_W)
  ) u_plan (
    .strap_i  (strap_i),
    .period_i (period_i),
    .nph_o    (plan_nph),
    .act_o    (plan_act),
    .off_o    (plan_off)
  );

  // capture on the first clock after reset, then run the shared counter
  always_comb begin
    det_d = det_q;
    act_d = act_q;
    per_d = per_q;
    cnt_d = cnt_q;
    for (int k = 0; k < MAX_PH; k++) begin
      off_d[k] = off_q[k];
    end
    if (!det_q) begin
      det_d = 1'b1;
      act_d = plan_act;
      per_d = period_i;
      cnt_d = '0;
      for (int k = 0; k < MAX_PH; k++) begin
        off_d[k] = plan_off[k];
      end
    end else if (cnt_q >= per_q - CNT_W'(1)) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  assign rip_d    = |start;
  assign drive_ok = dis_n_i && !hiz_i;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      det_q <= 1'b0;
      act_q <= '0;
      per_q <= '0;
      cnt_q <= '0;
      rip_q <= 1'b0;
      for (int k = 0; k < MAX_PH; k++) begin
        off_q[k] <= '0;
      end
    end else begin
      det_q <= det_d;
      act_q <= act_d;
      per_q <= per_d;
      cnt_q <= cnt_d;
      rip_q <= rip_d;
      for (int k = 0; k < MAX_PH; k++) begin
        off_q[k] <= off_d[k];
      end
    end
  end

  genvar k;
  generate
    for (k = 0; k < MAX_PH; k++) begin : g_ch
      mpwm_chan #(
        .CNT_W (CNT_W),
        .COR_W (COR_W)
      ) u_chan (
        .clk        (clk),
        .rst_n      (rst_int_n),
        .en_i       (det_q),
        .act_i      (act_q[k]),
        .drive_ok_i (drive_ok),
        .run_i      (run_i),
        .cnt_i      (cnt_q),
        .per_i      (per_q),
        .off_i      (off_q[k]),
        .duty_i     (duty_i),
        .corr_i     (corr_i[k*COR_W +: COR_W]),
        .drv_o      (drv[k]),
        .start_o    (start[k])
      );
      assign pwm_o[k]    = (drv[k] == DRV_HI);
      assign pwm_oe_o[k] = (drv[k] != DRV_OFF);
    end
  endgenerate

  assign ripple_o = rip_q;

endmodule

// File: rtl/mphase_pwm_chk.sv
module mphase_pwm_chk #(
  parameter int MAX_PH = 4,
  parameter int CNT_W  = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              dis_n_i,
  input logic              hiz_i,
  input logic              run_i,
  input logic [MAX_PH-1:0] pwm_o,
  input logic [MAX_PH-1:0] pwm_oe_o,
  input logic              ripple_o,
  input logic [MAX_PH-1:0] act_q,
  input logic              det_q,
  input logic [CNT_W-1:0]  cnt_q,
  input logic [CNT_W-1:0]  per_q
);

  a_r1_inactive_float: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_oe_o & ~act_q) == '0);

  a_r2_counter_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    det_q |-> (cnt_q < per_q));

  a_r4_high_only_driven: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_o & ~pwm_oe_o) == '0);

  a_r7_disable_floats: assert property (@(posedge clk) disable iff (!rst_n)
    !dis_n_i |=> (pwm_oe_o == '0));

  a_r8_hiz_floats: assert property (@(posedge clk) disable iff (!rst_n)
    hiz_i |=> (pwm_oe_o == '0));

  a_r8_run_low_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> (pwm_o == '0));

  a_r9_float_before_capture: assert property (@(posedge clk) disable iff (!rst_n)
    !det_q |-> ((pwm_oe_o == '0) && !ripple_o));

  a_r9_period_held: assert property (@(posedge clk) disable iff (!rst_n)
    det_q |=> $stable(per_q));

endmodule

bind mphase_pwm_gen mphase_pwm_chk #(
  .MAX_PH (MAX_PH),
  .CNT_W  (CNT_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .dis_n_i  (dis_n_i),
  .hiz_i    (hiz_i),
  .run_i    (run_i),
  .pwm_o    (pwm_o),
  .pwm_oe_o (pwm_oe_o),
  .ripple_o (ripple_o),
  .act_q    (act_q),
  .det_q    (det_q),
  .cnt_q    (cnt_q),
  .per_q    (per_q)
);

// File: tb/tb_mphase_pwm_gen.sv
module tb_mphase_pwm_gen;

  localparam int NCH  = 4;
  localparam int CW   = 10;
  localparam int CORW = 8;

  logic            clk;
  logic            rst_n;
  logic [NCH-1:0]  strap;
  logic [CW-1:0]   period;
  logic [CW-1:0]   duty;
  logic [NCH*CORW-1:0] corr;
  logic            run, hiz, dis_n;
  logic [NCH-1:0]  pwm, oe;
  logic            rip;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  mphase_pwm_gen #(.MAX_PH(NCH), .CNT_W(CW), .COR_W(CORW)) dut (
    .clk(clk), .rst_n(rst_n), .strap_i(strap), .period_i(period),
    .duty_i(duty), .corr_i(corr), .run_i(run), .hiz_i(hiz),
    .dis_n_i(dis_n), .pwm_o(pwm), .pwm_oe_o(oe), .ripple_o(rip)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // ---------------- reference model ----------------
  int e_m, cnt_m, p_m, n_m;
  int off_m  [NCH];
  int dcur_m [NCH];
  logic [NCH-1:0] exp_oe, exp_pwm;
  logic exp_rip;

  function automatic int phases_of(logic [NCH-1:0] s);
    int strip = 0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (s[i]) strip++;
      else break;
    end
    return (NCH - strip < 2) ? 2 : NCH - strip;
  endfunction

  function automatic int eff_of(int k, int p);
    int c, d;
    c = $signed(corr[k*CORW +: CORW]);
    d = int'(duty) - c;
    if (d < 0) d = 0;
    if (d > p - 1) d = p - 1;
    return d;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_m = 0; exp_oe = '0; exp_pwm = '0; exp_rip = 1'b0;
    end else begin
      e_m++;
      exp_oe = '0; exp_pwm = '0; exp_rip = 1'b0;
      if (e_m == 3) begin
        n_m = phases_of(strap);
        p_m = int'(period);
        for (int k = 0; k < NCH; k++) begin
          off_m[k]  = (k < n_m) ? (k * p_m) / n_m : 0;
          dcur_m[k] = 0;
        end
        cnt_m = 0;
      end else if (e_m >= 4) begin
        for (int k = 0; k < NCH; k++) begin
          int pos, ef;
          bit hi;
          pos = (cnt_m - off_m[k] + p_m) % p_m;
          ef  = eff_of(k, p_m);
          if (pos == 0) begin
            hi = (ef > 0);
            dcur_m[k] = ef;
          end else begin
            hi = (pos < dcur_m[k]);
          end
          if (k < n_m) begin
            if (pos == 0) exp_rip = 1'b1;
            if (dis_n && !hiz) begin
              exp_oe[k]  = 1'b1;
              exp_pwm[k] = run && hi;
            end
          end
        end
        cnt_m = (cnt_m + 1) % p_m;
      end
    end
  end

  // cycle-by-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (oe !== exp_oe) begin
        errors++;
        $display("FAIL R1/R7/R8 drive enable: got %b exp %b at %0t", oe, exp_oe, $time);
      end
      checks++;
      if (pwm !== exp_pwm) begin
        errors++;
        $display("FAIL R4/R5/R6/R10 level: got %b exp %b at %0t", pwm, exp_pwm, $time);
      end
      checks++;
      if (rip !== exp_rip) begin
        errors++;
        $display("FAIL R2/R3 ripple: got %b exp %b at %0t", rip, exp_rip, $time);
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic check(input string req, input int got, input int expv);
    checks++;
    if (got != expv) begin
      errors++;
      $display("FAIL %s: got %0d exp %0d", req, got, expv);
    end
  endtask

  task automatic set_corr(input int c0, input int c1, input int c2, input int c3);
    corr[0*CORW +: CORW] = CORW'(c0);
    corr[1*CORW +: CORW] = CORW'(c1);
    corr[2*CORW +: CORW] = CORW'(c2);
    corr[3*CORW +: CORW] = CORW'(c3);
  endtask

  task automatic restart(input logic [NCH-1:0] s, input int p);
    @(negedge clk);
    rst_n  = 1'b0;
    strap  = s;
    period = CW'(p);
    repeat (3) @(negedge clk);
    // R9: reset state, all floating and quiet
    check("R9 oe in reset", int'(oe), 0);
    check("R9 pwm in reset", int'(pwm), 0);
    check("R9 ripple in reset", int'(rip), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R9 oe before capture", int'(oe), 0);
    repeat (4) @(negedge clk);
  endtask

  // count high cycles of channel k and ripple pulses over p cycles
  task automatic window(input int k, input int p, output int hi_n, output int rip_n);
    hi_n = 0; rip_n = 0;
    for (int i = 0; i < p; i++) begin
      @(negedge clk);
      hi_n  += int'(pwm[k]);
      rip_n += int'(rip);
    end
  endtask

  // cycles from a rising edge of channel a to the next rising edge of b
  task automatic rise_gap(input int a, input int b, output int gap);
    logic prev;
    prev = pwm[a];
    forever begin
      @(negedge clk);
      if (pwm[a] && !prev) break;
      prev = pwm[a];
    end
    gap = 0;
    prev = pwm[b];
    forever begin
      @(negedge clk);
      gap++;
      if (pwm[b] && !prev) break;
      prev = pwm[b];
    end
  endtask

  // ---------------- stimulus ----------------
  initial begin
    int h, r, g;
    rst_n = 1'b0; strap = '0; period = CW'(20); duty = CW'(8);
    corr = '0; run = 1'b1; hiz = 1'b0; dis_n = 1'b1;

    // four phases, P=20, offsets 0,5,10,15
    restart(4'b0000, 20);
    repeat (40) @(negedge clk);
    for (int k = 0; k < 4; k++) begin
      window(k, 20, h, r);
      check("R4 width duty 8", h, 8);
      check("R3 four pulses per period", r, 4);
    end
    rise_gap(0, 1, g);
    check("R2 spacing P/4", g, 5);

    set_corr(0, 3, -5, 0);
    repeat (45) @(negedge clk);
    window(1, 20, h, r);
    check("R5 ch1 narrowed by +3", h, 5);
    window(2, 20, h, r);
    check("R5 ch2 widened by -5", h, 13);

    set_corr(0, 0, 0, 0);
    duty = CW'(25);
    repeat (45) @(negedge clk);
    window(3, 20, h, r);
    check("R5 clamp to P-1", h, 19);

    duty = CW'(2);
    set_corr(5, 0, 0, 0);
    repeat (45) @(negedge clk);
    window(0, 20, h, r);
    check("R5 clamp to zero", h, 0);
    window(1, 20, h, r);
    check("R4 short pulse", h, 2);

    // R6: duty changes at awkward moments; the model checks every cycle
    set_corr(-2, 4, 1, -3);
    for (int i = 0; i < 30; i++) begin
      duty = CW'((i * 7) % 23);
      repeat (7) @(negedge clk);
    end
    duty = CW'(10);
    set_corr(0, 0, 0, 0);
    repeat (45) @(negedge clk);

    // R7 disable, R10 one edge of latency
    dis_n = 1'b0;
    @(negedge clk);
    check("R7 float one edge after disable", int'(oe), 0);
    repeat (5) @(negedge clk);
    dis_n = 1'b1;
    @(negedge clk);
    check("R10 drive back after one edge", int'(oe), 4'hF);

    // R8 float request and run low
    hiz = 1'b1;
    @(negedge clk);
    check("R8 float request", int'(oe), 0);
    hiz = 1'b0;
    run = 1'b0;
    @(negedge clk);
    check("R8 run low keeps drive", int'(oe), 4'hF);
    window(0, 20, h, r);
    check("R8 run low holds low", h, 0);
    run = 1'b1;

    // R9: later period changes are ignored
    period = CW'(7);
    repeat (30) @(negedge clk);
    window(2, 20, h, r);
    check("R9 period held, ripple count", r, 4);
    check("R9 period held, width", h, 10);

    // three phases: pad 3 strapped, P=30, offsets 0,10,20
    duty = CW'(12);
    restart(4'b1000, 30);
    repeat (60) @(negedge clk);
    window(2, 30, h, r);
    check("R3 three pulses per period", r, 3);
    check("R4 width with three phases", h, 12);
    check("R1 channel 3 floats", int'(oe[3]), 0);
    rise_gap(1, 2, g);
    check("R2 spacing P/3", g, 10);

    // two phases: pads 3 and 2 strapped, P=16
    duty = CW'(5);
    restart(4'b1100, 16);
    repeat (40) @(negedge clk);
    window(1, 16, h, r);
    check("R3 two pulses per period", r, 2);
    check("R1 two phases drive mask", int'(oe), 4'b0011);

    // three high straps still give two phases; odd period rounds down
    duty = CW'(3);
    restart(4'b1110, 9);
    repeat (30) @(negedge clk);
    check("R1 floor of two phases", int'(oe), 4'b0011);
    rise_gap(0, 1, g);
    check("R2 offset floor(9/2)", g, 4);
    repeat (20) @(negedge clk);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule